// File: doc/BRIEF.md
# Line Brown-out Blanking Detector

This block decides when a power-factor stage must stop because the mains has sagged. It watches one comparator flag, already synchronised to the clock, that is high while the averaged line sense voltage is under its 1.0 V trip level. A sag is only treated as a brown-out once it has lasted a full blanking delay. The delay is counted in prescaled ticks, nominally 500 ticks. Shorter mains interruptions are ridden through, which protects hold-up time.

While a sag is being blanked, a clamp request keeps the sense pin just under the trip level. Once brown-out is declared, the flag halts switching and drops the downstream ready indication. A hysteresis current source is switched in, and a one-cycle pulse clears any latched-off state. Recovery is judged over a separate monitoring window of nominally 50 ticks, one tenth of the blanking delay. The line must stay above the trip level for the whole window before normal operation resumes.

Top module: `brownout_blanker`

## Requirements
- R1: After reset, `brownout_o`, `hyst_en_o` and `latch_clr_o` are 0, and `clamp_en_o` follows `below_i`.
- R2: With `below_i` held at 1, `brownout_o` rises on the clock edge that samples the BLANK_TICKS-th tick, and not on any earlier edge.
- R3: If `below_i` returns to 0 before blanking completes, the tick count restarts from zero and no brown-out is reported.
- R4: `clamp_en_o` is 1 exactly when `below_i` is 1 and `brownout_o` is 0. It responds in the same cycle as `below_i`.
- R5: While `brownout_o` is 1, `hyst_en_o` is 1. `brownout_o` is active high and means stop switching and drive ready low.
- R6: `latch_clr_o` is a single-cycle pulse in the first cycle that `brownout_o` is 1, and it is 0 at all other times.
- R7: In brown-out, `brownout_o` and `hyst_en_o` fall on the edge that samples the WIN_TICKS-th consecutive tick with `below_i` at 0. Any cycle with `below_i` at 1 restarts the window.
- R8: Cycles with `tick_i` at 0 do not advance the blanking count or the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled timing tick, one cycle wide |
| below_i | input | 1 | Synchronised comparator flag, 1 = line sense under trip level |
| brownout_o | output | 1 | Brown-out declared: stop switching, ready low |
| hyst_en_o | output | 1 | Enable for the hysteresis current source |
| clamp_en_o | output | 1 | Clamp request while a sag is being blanked |
| latch_clr_o | output | 1 | One-cycle pulse that clears a latched-off state |

## Verification
The blanking counter is tested with an unbroken sag, a sag with tickless cycles mixed in, and a sag cut short one tick before expiry. Together these show that the count is exact, that it depends on ticks rather than cycles, and that it restarts when the sag ends. Recovery is tested with a clean window and with a window broken by a single low-line cycle, which shows that the window restarts. A reset applied during brown-out shows that the state clears even when the line is still low.

// File: rtl/brownout_blanker.sv
module brownout_blanker #(
  parameter int BLANK_TICKS = 500,
  parameter int WIN_TICKS   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic below_i,
  output logic brownout_o,
  output logic hyst_en_o,
  output logic clamp_en_o,
  output logic latch_clr_o
);

  localparam int MAX_TICKS = (BLANK_TICKS > WIN_TICKS) ? BLANK_TICKS : WIN_TICKS;
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_TICKS - 1);
  localparam logic [CW-1:0] WIN_LAST   = CW'(WIN_TICKS - 1);

  logic          bo_q;
  logic          lc_q;
  logic [CW-1:0] cnt_q;
  logic          gather;
  logic          expire;

  // while normal, count low-line time; while in brown-out, count good-line time
  assign gather = bo_q ? ~below_i : below_i;
  assign expire = tick_i & gather & (cnt_q == (bo_q ? WIN_LAST : BLANK_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_q  <= 1'b0;
      lc_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      lc_q <= 1'b0;
      if (!gather) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (expire) begin
          cnt_q <= '0;
          bo_q  <= ~bo_q;
          lc_q  <= ~bo_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign brownout_o  = bo_q;
  assign hyst_en_o   = bo_q;
  assign clamp_en_o  = below_i & ~bo_q;
  assign latch_clr_o = lc_q;

  // R2
  bo_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brownout_o) |-> $past(below_i && tick_i));

  // R7
  bo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brownout_o) |-> $past(!below_i && tick_i));

  // R6
  lc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brownout_o) |-> latch_clr_o);

  // R6
  lc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr_o |=> !latch_clr_o);

  // R8
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(brownout_o));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ((BLANK_LAST > WIN_LAST) ? BLANK_LAST : WIN_LAST));

endmodule

// File: tb/brownout_blanker_tb.sv
module brownout_blanker_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic below_i = 1'b0;
  logic brownout_o, hyst_en_o, clamp_en_o, latch_clr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  brownout_blanker #(.BLANK_TICKS(4), .WIN_TICKS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .below_i(below_i),
    .brownout_o(brownout_o), .hyst_en_o(hyst_en_o),
    .clamp_en_o(clamp_en_o), .latch_clr_o(latch_clr_o)
  );

  // {req[3:0], below, tick, exp_bo, exp_clamp, exp_lc}
  localparam logic [8:0] VEC [0:16] = '{
    {4'd2, 5'b11_010},  // R2 tick 1
    {4'd8, 5'b10_010},  // R8 no tick, no advance
    {4'd2, 5'b11_010},  // tick 2
    {4'd2, 5'b11_010},  // tick 3
    {4'd3, 5'b01_000},  // R3 line back, count restarts
    {4'd3, 5'b11_010},
    {4'd3, 5'b11_010},
    {4'd3, 5'b11_010},  // only 3 ticks since restart
    {4'd6, 5'b11_101},  // R2 R6 4th tick -> brown-out, clear pulse
    {4'd6, 5'b11_100},  // R6 pulse gone, R4 clamp off
    {4'd7, 5'b01_100},  // R7 window tick 1
    {4'd8, 5'b00_100},  // R8 no tick
    {4'd7, 5'b11_100},  // R7 low line restarts window
    {4'd7, 5'b01_100},
    {4'd7, 5'b01_100},
    {4'd7, 5'b01_000},  // R7 3rd good tick -> recover, R5 hyst off
    {4'd4, 5'b10_010}   // R4 clamp follows below
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic t);
    @(negedge clk);
    below_i = b;
    tick_i  = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(1, "brownout", brownout_o, 1'b0);
    chk(1, "hyst", hyst_en_o, 1'b0);
    chk(1, "latch_clr", latch_clr_o, 1'b0);
    below_i = 1'b1;
    #1;
    chk(1, "clamp follows below", clamp_en_o, 1'b1);
    below_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 17; i++) begin
      step(VEC[i][4], VEC[i][3]);
      chk(int'(VEC[i][8:5]), $sformatf("vec %0d brownout", i), brownout_o, VEC[i][2]);
      chk(5, $sformatf("vec %0d hyst", i), hyst_en_o, VEC[i][2]);
      chk(4, $sformatf("vec %0d clamp", i), clamp_en_o, VEC[i][1]);
      chk(6, $sformatf("vec %0d latch_clr", i), latch_clr_o, VEC[i][0]);
    end

    // R2 long tickless gap inside a sag, then exact count
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    chk(8, "no advance without ticks", brownout_o, 1'b0);
    step(1'b1, 1'b1);
    chk(2, "declared on 4th tick", brownout_o, 1'b1);
    chk(6, "clear pulse", latch_clr_o, 1'b1);

    // R1 reset during brown-out with line still low
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(1, "async reset brownout", brownout_o, 1'b0);
    chk(4, "clamp after reset", clamp_en_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1);
    chk(3, "count restarted by reset", brownout_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule